// File: doc/BRIEF.md
# Endpoint DMA Request Selector

This block drives one DMA request line on behalf of one of six endpoints. Endpoints 1, 3 and 5 send data and endpoints 2, 4 and 6 receive it. A configuration register chooses the endpoint and sets the condition that raises the request. It holds an enable bit, a trigger-mode bit and a 3-bit binary endpoint code. Each endpoint supplies a status event: transmit endpoints report that a transmit has finished, and receive endpoints report that the last packet of a reception has arrived. Each endpoint also supplies a FIFO-warning level.

In completion mode, the selected endpoint's status event sets a sticky request. The request stays high until the DMA engine acknowledges it. In warning mode, the request follows the selected endpoint's FIFO-warning level one cycle later, as long as the enable bit is set. Any write to the configuration register drops the request, so a request raised for one endpoint never appears to come from a newly selected one.

Top module: `ep_dma_req_sel`

## Requirements
- R1: After reset, `dma_req` is 0 and the register holds all zeros. Until the register is written, no status event, warning or acknowledge raises `dma_req`.
- R2: The write data is decoded as follows:
  - bit 7 is the enable;
  - bit 3 is the mode (0 = completion, 1 = warning);
  - bits 2:0 are the endpoint code.
  Bits 6:4 are ignored.
- R3: Endpoint codes 0 to 5 select endpoints 1 to 6. Codes 6 and 7 are reserved, and with a reserved code `dma_req` stays 0 whatever the inputs do.
- R4: While the enable bit is 0, `dma_req` stays 0.
- R5: In completion mode with a transmit endpoint selected, `tx_done[k]` (the event for endpoint 2k+1) sets `dma_req` from the cycle after it is sampled. Events of other endpoints have no effect.
- R6: In completion mode with a receive endpoint selected, `rx_last[k]` (the event for endpoint 2k+2) sets `dma_req` from the cycle after it is sampled. Events of other endpoints, including transmit events, have no effect.
- R7: In completion mode the request stays high until `dma_ack` is sampled, and it is 0 on the next cycle. If the selected event arrives in the same cycle as the acknowledge, the request stays set.
- R8: In warning mode, `dma_req` equals the `fifo_warn` bit of the selected endpoint (bit n-1 for endpoint n) as sampled one cycle earlier. Completion events and `dma_ack` have no effect.
- R9: A sampled `cfg_we` makes `dma_req` 0 on the next cycle, even if a trigger is present in that same cycle.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| cfg_we | input | 1 | Configuration register write strobe |
| cfg_wdata | input | 8 | Configuration write data |
| tx_done | input | 3 | Transmit-finished events, bit k for endpoint 2k+1 |
| rx_last | input | 3 | Last-receive events, bit k for endpoint 2k+2 |
| fifo_warn | input | 6 | FIFO warning levels, bit n-1 for endpoint n |
| dma_ack | input | 1 | DMA acknowledge |
| dma_req | output | 1 | DMA request |

## Verification
The bench aims at the following corner cases:
- **Direction routing.** It raises the receive event of the transmit endpoint's neighbour, and the transmit event of a receive endpoint. A design that routes by endpoint number and ignores direction would raise a request on the wrong event.
- **Same-cycle priority.** It sends an acknowledge together with a new event, and a register write together with an event. A design with the wrong priority would drop a fresh request in the first case, or keep a stale one in the second.
- **Reserved codes.** It drives every input while a reserved endpoint code is selected. A design that decoded the reserved codes onto some endpoint would request spuriously.
- **Warning mode.** It shows that the acknowledge cannot clear a level-following request and that completion events cannot set one.

// File: rtl/epdma_pkg.sv
package epdma_pkg;

    localparam int EPDMA_NUM_EP   = 6;
    localparam int EPDMA_NUM_PAIR = EPDMA_NUM_EP / 2;
    localparam int EPDMA_SEL_W    = $clog2(EPDMA_NUM_EP);
    localparam int EPDMA_REG_W    = 8;

    // Field positions in the configuration write word
    localparam int EPDMA_EN_BIT   = 7;
    localparam int EPDMA_MODE_BIT = 3;
    localparam int EPDMA_SEL_LSB  = 0;

    typedef struct packed {
        logic                   en;
        logic                   warn_mode;
        logic [EPDMA_SEL_W-1:0] sel;
    } epdma_cfg_t;

    typedef struct packed {
        logic req;
    } epdma_req_t;

endpackage

// File: rtl/epdma_cfg_reg.sv
module epdma_cfg_reg
    import epdma_pkg::*;
#(
    parameter int REG_W = EPDMA_REG_W
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             cfg_we,
    input  logic [REG_W-1:0] cfg_wdata,
    output epdma_cfg_t       cfg_q
);

    epdma_cfg_t cfg_d;

    always_comb begin
        cfg_d = cfg_q;
        if (cfg_we) begin
            cfg_d.en        = cfg_wdata[EPDMA_EN_BIT];
            cfg_d.warn_mode = cfg_wdata[EPDMA_MODE_BIT];
            cfg_d.sel       = cfg_wdata[EPDMA_SEL_LSB +: EPDMA_SEL_W];
        end
    end

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            cfg_q <= '0;
        end else begin
            cfg_q <= cfg_d;
        end
    end

endmodule

// File: rtl/epdma_trig_mux.sv
module epdma_trig_mux
    import epdma_pkg::*;
#(
    parameter int NUM_EP = EPDMA_NUM_EP
) (
    input  epdma_cfg_t          cfg,
    input  logic [NUM_EP/2-1:0] tx_done,
    input  logic [NUM_EP/2-1:0] rx_last,
    input  logic [NUM_EP-1:0]   fifo_warn,
    output logic                sel_ok,
    output logic                compl_evt,
    output logic                warn_lvl
);

    localparam int NUM_PAIR = NUM_EP / 2;

    // Completion event per endpoint:
    // even index = transmit endpoint, odd index = receive endpoint.
    logic [NUM_EP-1:0] done_vec;

    for (genvar k = 0; k < NUM_PAIR; k++) begin : g_pair
        assign done_vec[2*k]   = tx_done[k];
        assign done_vec[2*k+1] = rx_last[k];
    end

    always_comb begin
        sel_ok    = 1'b0;
        compl_evt = 1'b0;
        warn_lvl  = 1'b0;
        for (int i = 0; i < NUM_EP; i++) begin
            if (cfg.sel == EPDMA_SEL_W'(i)) begin
                sel_ok    = 1'b1;
                compl_evt = done_vec[i];
                warn_lvl  = fifo_warn[i];
            end
        end
    end

endmodule

// File: rtl/epdma_req_ctl.sv
module epdma_req_ctl
    import epdma_pkg::*;
(
    input  logic       clk,
    input  logic       rst_n,
    input  epdma_cfg_t cfg,
    input  logic       cfg_we,
    input  logic       sel_ok,
    input  logic       compl_evt,
    input  logic       warn_lvl,
    input  logic       dma_ack,
    output logic       req
);

    epdma_req_t st_d, st_q;

    always_comb begin
        st_d = st_q;
        if (cfg_we || !cfg.en || !sel_ok) begin
            st_d.req = 1'b0;
        end else if (cfg.warn_mode) begin
            st_d.req = warn_lvl;
        end else if (compl_evt) begin
            st_d.req = 1'b1;
        end else if (dma_ack) begin
            st_d.req = 1'b0;
        end
    end

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            st_q <= '0;
        end else begin
            st_q <= st_d;
        end
    end

    assign req = st_q.req;

endmodule

// File: rtl/ep_dma_req_sel.sv
module ep_dma_req_sel
    import epdma_pkg::*;
#(
    parameter int NUM_EP = EPDMA_NUM_EP,
    parameter int REG_W  = EPDMA_REG_W
) (
    input  logic                clk,
    input  logic                rst_n,
    input  logic                cfg_we,
    input  logic [REG_W-1:0]    cfg_wdata,
    input  logic [NUM_EP/2-1:0] tx_done,
    input  logic [NUM_EP/2-1:0] rx_last,
    input  logic [NUM_EP-1:0]   fifo_warn,
    input  logic                dma_ack,
    output logic                dma_req
);

    epdma_cfg_t cfg_q;
    logic       sel_ok;
    logic       compl_evt;
    logic       warn_lvl;

    epdma_cfg_reg #(
        .REG_W(REG_W)
    ) u_cfg (
        .clk       (clk),
        .rst_n     (rst_n),
        .cfg_we    (cfg_we),
        .cfg_wdata (cfg_wdata),
        .cfg_q     (cfg_q)
    );

    epdma_trig_mux #(
        .NUM_EP(NUM_EP)
    ) u_mux (
        .cfg       (cfg_q),
        .tx_done   (tx_done),
        .rx_last   (rx_last),
        .fifo_warn (fifo_warn),
        .sel_ok    (sel_ok),
        .compl_evt (compl_evt),
        .warn_lvl  (warn_lvl)
    );

    epdma_req_ctl u_ctl (
        .clk       (clk),
        .rst_n     (rst_n),
        .cfg       (cfg_q),
        .cfg_we    (cfg_we),
        .sel_ok    (sel_ok),
        .compl_evt (compl_evt),
        .warn_lvl  (warn_lvl),
        .dma_ack   (dma_ack),
        .req       (dma_req)
    );

endmodule

// File: rtl/epdma_chk.sv
module epdma_chk
    import epdma_pkg::*;
(
    input logic       clk,
    input logic       rst_n,
    input logic       cfg_we,
    input logic       dma_ack,
    input logic       dma_req,
    input epdma_cfg_t cfg_q,
    input logic       sel_ok,
    input logic       compl_evt,
    input logic       warn_lvl
);

    AST_WRITE_DROPS_REQ: assert property (@(posedge clk) disable iff (!rst_n)
        cfg_we |=> !dma_req); // R9

    AST_DISABLED_IDLE: assert property (@(posedge clk) disable iff (!rst_n)
        (!cfg_we && !cfg_q.en) |=> !dma_req); // R4

    AST_RESERVED_IDLE: assert property (@(posedge clk) disable iff (!rst_n)
        (!cfg_we && !sel_ok) |=> !dma_req); // R3

    AST_EVENT_SETS: assert property (@(posedge clk) disable iff (!rst_n)
        (!cfg_we && cfg_q.en && sel_ok && !cfg_q.warn_mode && compl_evt) |=> dma_req); // R5

    AST_HOLD_TILL_ACK: assert property (@(posedge clk) disable iff (!rst_n)
        (!cfg_we && cfg_q.en && !cfg_q.warn_mode && dma_req && !dma_ack) |=> dma_req); // R7

    AST_ACK_CLEARS: assert property (@(posedge clk) disable iff (!rst_n)
        (!cfg_we && !cfg_q.warn_mode && dma_ack && !compl_evt) |=> !dma_req); // R7

    AST_WARN_FOLLOWS: assert property (@(posedge clk) disable iff (!rst_n)
        (!cfg_we && cfg_q.en && sel_ok && cfg_q.warn_mode) |=> (dma_req == $past(warn_lvl))); // R8

endmodule

bind ep_dma_req_sel epdma_chk u_chk (
    .clk       (clk),
    .rst_n     (rst_n),
    .cfg_we    (cfg_we),
    .dma_ack   (dma_ack),
    .dma_req   (dma_req),
    .cfg_q     (cfg_q),
    .sel_ok    (sel_ok),
    .compl_evt (compl_evt),
    .warn_lvl  (warn_lvl)
);

// File: tb/ep_dma_req_sel_tb.sv
module ep_dma_req_sel_tb;

    logic       clk = 1'b0;
    logic       rst_n = 1'b0;
    logic       cfg_we = 1'b0;
    logic [7:0] cfg_wdata = '0;
    logic [2:0] tx_done = '0;
    logic [2:0] rx_last = '0;
    logic [5:0] fifo_warn = '0;
    logic       dma_ack = 1'b0;
    logic       dma_req;

    int checks = 0;
    int errors = 0;

    typedef struct {
        bit    exp;
        string tag;
    } item_t;

    item_t sb_q[$];
    bit    mon_on = 1'b0;

    always #4 clk = ~clk;

    ep_dma_req_sel u_dut (
        .clk       (clk),
        .rst_n     (rst_n),
        .cfg_we    (cfg_we),
        .cfg_wdata (cfg_wdata),
        .tx_done   (tx_done),
        .rx_last   (rx_last),
        .fifo_warn (fifo_warn),
        .dma_ack   (dma_ack),
        .dma_req   (dma_req)
    );

    // Driver: one cycle of stimulus, plus the expected request after the next edge
    task automatic step(input bit we, input logic [7:0] wd, input logic [2:0] tx,
                        input logic [2:0] rx, input logic [5:0] wn, input bit ack,
                        input bit exp, input string tag);
        @(negedge clk);
        cfg_we    = we;
        cfg_wdata = wd;
        tx_done   = tx;
        rx_last   = rx;
        fifo_warn = wn;
        dma_ack   = ack;
        sb_q.push_back('{exp: exp, tag: tag});
    endtask

    task automatic wr(input logic [7:0] wd, input string tag);
        step(1'b1, wd, 3'b000, 3'b000, 6'b000000, 1'b0, 1'b0, tag);
    endtask

    // Monitor: compares the output shortly after each edge
    always @(posedge clk) begin
        if (mon_on && sb_q.size() > 0) begin
            item_t it;
            #2;
            it = sb_q.pop_front();
            checks++;
            if (dma_req !== it.exp) begin
                errors++;
                $display("FAIL %s: dma_req actual %0b expected %0b", it.tag, dma_req, it.exp);
            end
        end
    end

    initial begin
        #1_000_000;
        errors++;
        $display("FAIL watchdog: run did not complete, actual hung expected done");
        $display("  CHECKS %0d ERRORS %0d", checks, errors);
        $finish;
    end

    initial begin
        repeat (3) @(negedge clk);
        rst_n = 1'b1;
        @(negedge clk);
        checks++;
        if (dma_req !== 1'b0) begin
            errors++;
            $display("FAIL R1: reset dma_req actual %0b expected 0", dma_req);
        end
        mon_on = 1'b1;

        // R1: the reset register is disabled, so nothing requests
        step(0, 8'h00, 3'b111, 3'b111, 6'h3F, 0, 0, "R1");
        step(0, 8'h00, 3'b111, 3'b111, 6'h3F, 1, 0, "R1");

        // Endpoint 1, completion mode
        wr(8'h80, "R9");
        step(0, 8'h00, 3'b001, 3'b000, 6'h00, 0, 1, "R5");
        step(0, 8'h00, 3'b000, 3'b000, 6'h00, 0, 1, "R7");
        step(0, 8'h00, 3'b000, 3'b000, 6'h00, 0, 1, "R7");
        step(0, 8'h00, 3'b000, 3'b000, 6'h00, 1, 0, "R7");
        step(0, 8'h00, 3'b010, 3'b000, 6'h00, 0, 0, "R5");
        step(0, 8'h00, 3'b000, 3'b001, 6'h00, 0, 0, "R6");
        step(0, 8'h00, 3'b000, 3'b000, 6'h01, 0, 0, "R5");

        // Endpoint 4, receive
        wr(8'h83, "R9");
        step(0, 8'h00, 3'b010, 3'b000, 6'h00, 0, 0, "R6");
        step(0, 8'h00, 3'b000, 3'b010, 6'h00, 0, 1, "R6");
        step(0, 8'h00, 3'b000, 3'b010, 6'h00, 1, 1, "R7");
        step(0, 8'h00, 3'b000, 3'b000, 6'h00, 1, 0, "R7");

        // Endpoint 6, receive; a write that coincides with an event clears
        wr(8'h85, "R9");
        step(0, 8'h00, 3'b000, 3'b100, 6'h00, 0, 1, "R6");
        step(1, 8'h85, 3'b000, 3'b100, 6'h00, 0, 0, "R9");
        step(0, 8'h00, 3'b000, 3'b000, 6'h00, 0, 0, "R9");

        // Reserved codes
        wr(8'h86, "R3");
        step(0, 8'h00, 3'b111, 3'b111, 6'h3F, 0, 0, "R3");
        wr(8'h8E, "R3");
        step(0, 8'h00, 3'b111, 3'b111, 6'h3F, 0, 0, "R3");
        wr(8'h87, "R3");
        step(0, 8'h00, 3'b111, 3'b111, 6'h3F, 0, 0, "R3");

        // Enable low
        wr(8'h04, "R4");
        step(0, 8'h00, 3'b100, 3'b000, 6'h10, 0, 0, "R4");
        wr(8'h0C, "R4");
        step(0, 8'h00, 3'b000, 3'b000, 6'h10, 0, 0, "R4");

        // Bits 6:4 ignored; endpoint 5 completion
        wr(8'hF4, "R2");
        step(0, 8'h00, 3'b000, 3'b100, 6'h00, 0, 0, "R2");
        step(0, 8'h00, 3'b100, 3'b000, 6'h00, 0, 1, "R2");
        step(0, 8'h00, 3'b000, 3'b000, 6'h00, 1, 0, "R7");

        // Endpoint 2, warning mode
        wr(8'h89, "R8");
        step(0, 8'h00, 3'b000, 3'b000, 6'h02, 0, 1, "R8");
        step(0, 8'h00, 3'b000, 3'b000, 6'h02, 1, 1, "R8");
        step(0, 8'h00, 3'b000, 3'b000, 6'h00, 0, 0, "R8");
        step(0, 8'h00, 3'b111, 3'b001, 6'h00, 0, 0, "R8");
        step(0, 8'h00, 3'b000, 3'b000, 6'h3D, 0, 0, "R8");
        step(1, 8'h89, 3'b000, 3'b000, 6'h02, 0, 0, "R9");
        step(0, 8'h00, 3'b000, 3'b000, 6'h02, 0, 1, "R8");

        // Endpoint 3, warning mode
        wr(8'h8A, "R8");
        step(0, 8'h00, 3'b000, 3'b000, 6'h04, 0, 1, "R8");
        step(0, 8'h00, 3'b000, 3'b000, 6'h00, 0, 0, "R8");

        step(0, 8'h00, 3'b000, 3'b000, 6'h00, 0, 0, "R8");
        @(negedge clk);
        @(negedge clk);
        $display("  CHECKS %0d ERRORS %0d", checks, errors);
        $finish;
    end

endmodule